// File: doc/BRIEF.md
# Background Tile Pixel Shifter

This block turns a stream of fetched tile data into one background pixel per dot. It has four 16-bit right-shifting registers. Two hold the low and high pattern planes and two hold the attribute planes. Every eighth dot the fetch logic presents a new tile's two pattern bytes and its 2-bit palette attribute. The block loads them into the upper halves, so the tile on screen now drains out of the lower halves while the next tile waits above it.

The pattern bytes are bit-reversed as they load. The leftmost pixel of a tile is its byte's most significant bit, and reversal puts that pixel at the low end of the upper half, nearest the tap. A 3-bit fine horizontal scroll value then picks the bit to tap, from 0 to 7. It does not delay the data. The two tapped pattern bits form the pixel index, and the two tapped attribute bits select one of four palettes. Together they build the palette-RAM address that the block drives out.

Top module: `bg_pixel_shifter`

## Requirements
- R1: While `rst_n` is low all four shift registers clear. After reset, with no load, `pix_idx` is 0 and `pal_addr` is 0x3F00 for every fine-x value.
- R2: On `reload`, pattern byte bit 7 lands in register bit 8 and byte bit 0 in bit 15, ORed into the upper half. The byte is reversed because pixel 0 of the tile is byte bit 7.
- R3: On `reload`, each attribute register's bits 15..8 are filled with copies of one attribute bit. `attr_in[0]` fills the low attribute register and `attr_in[1]` fills the high one.
- R4: When `shift_en` is high, each register shifts right by one and a 0 enters bit 15. With neither `shift_en` nor `reload` high, every register holds its value.
- R5: `pix_idx` is {high-plane bit at `fine_x`, low-plane bit at `fine_x`}, so bit 1 is the high plane.
- R6: `pal_addr` is 0x3F00 OR (high attribute bit at `fine_x` << 3) OR (low attribute bit at `fine_x` << 2) OR `pix_idx`.
- R7: With `bg_en` low, `pix_idx` is 0 while the attribute bits still appear in `pal_addr` bits 3..2.
- R8: When `reload` and `shift_en` are high in the same cycle, the shift is applied first and the new tile is then ORed into bits 15..8.
- R9: Every `fine_x` value from 0 to 7 taps its own bit, and a change of `fine_x` changes the outputs in the same cycle without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_en | input | 1 | Shift all registers right by one this dot |
| reload | input | 1 | Load the next tile into the upper halves |
| pat_lo_in | input | 8 | Low-plane pattern byte of the next tile |
| pat_hi_in | input | 8 | High-plane pattern byte of the next tile |
| attr_in | input | 2 | Palette attribute of the next tile |
| fine_x | input | 3 | Fine horizontal scroll, the tap position |
| bg_en | input | 1 | Background display enable |
| pix_idx | output | 2 | Background pixel index |
| pal_addr | output | 14 | Palette-RAM address |

## Verification
A tile reload and a shift fall in the same cycle at every tile boundary. This is where a wrong ordering would corrupt or drop a pixel. The bench raises both strobes together on every eighth shift, after seven plain shifts have drained the previous tile out of the upper half. It then judges the result against a reference pixel stream, computed arithmetically from known tile bytes and tapped at all eight fine-x positions after every dot. Stall dots and dots with the background disabled are mixed into the same stream. These show that holding keeps the stream in place and that blanking keeps the palette selection.

// File: rtl/bg_pixel_shifter.sv
module bg_pixel_shifter #(
  parameter int TILE_W = 8,
  parameter int PAL_W = 14,
  parameter logic [PAL_W-1:0] PAL_BASE = 14'h3F00,
  localparam int REG_W = 2 * TILE_W,
  localparam int FX_W = $clog2(TILE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              reload,
  input  logic [TILE_W-1:0] pat_lo_in,
  input  logic [TILE_W-1:0] pat_hi_in,
  input  logic [1:0]        attr_in,
  input  logic [FX_W-1:0]   fine_x,
  input  logic              bg_en,
  output logic [1:0]        pix_idx,
  output logic [PAL_W-1:0]  pal_addr
);

  function automatic logic [TILE_W-1:0] flip(input logic [TILE_W-1:0] b);
    for (int i = 0; i < TILE_W; i++) flip[i] = b[TILE_W-1-i];
  endfunction

  logic [REG_W-1:0] plo_q, phi_q, alo_q, ahi_q;
  logic [REG_W-1:0] plo_d, phi_d, alo_d, ahi_d;
  logic [REG_W-1:0] ld_mask;

  assign ld_mask = {REG_W{reload}};

  // shift first, then merge the incoming tile into the upper half
  assign plo_d = (shift_en ? plo_q >> 1 : plo_q) | (ld_mask & {flip(pat_lo_in), {TILE_W{1'b0}}});
  assign phi_d = (shift_en ? phi_q >> 1 : phi_q) | (ld_mask & {flip(pat_hi_in), {TILE_W{1'b0}}});
  assign alo_d = (shift_en ? alo_q >> 1 : alo_q) | (ld_mask & {{TILE_W{attr_in[0]}}, {TILE_W{1'b0}}});
  assign ahi_d = (shift_en ? ahi_q >> 1 : ahi_q) | (ld_mask & {{TILE_W{attr_in[1]}}, {TILE_W{1'b0}}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      plo_q <= '0;
      phi_q <= '0;
      alo_q <= '0;
      ahi_q <= '0;
    end else begin
      plo_q <= plo_d;
      phi_q <= phi_d;
      alo_q <= alo_d;
      ahi_q <= ahi_d;
    end
  end

  assign pix_idx  = bg_en ? {phi_q[fine_x], plo_q[fine_x]} : 2'b00;
  assign pal_addr = PAL_BASE | PAL_W'({ahi_q[fine_x], alo_q[fine_x], pix_idx});

  // R8
  reload_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |-> (shift_en ? (plo_q[REG_W-1:TILE_W+1] == '0 && phi_q[REG_W-1:TILE_W+1] == '0)
                         : (plo_q[REG_W-1:TILE_W] == '0 && phi_q[REG_W-1:TILE_W] == '0)));

  // R4
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !reload) |=> (plo_q == ($past(plo_q) >> 1) && ahi_q == ($past(ahi_q) >> 1)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !reload) |=> ($stable(plo_q) && $stable(phi_q) && $stable(alo_q) && $stable(ahi_q)));

  // R3
  attr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> ((alo_q[REG_W-1:TILE_W] == '0 || alo_q[REG_W-1:TILE_W] == '1) &&
                (ahi_q[REG_W-1:TILE_W] == '0 || ahi_q[REG_W-1:TILE_W] == '1)));

  // R7
  blank_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bg_en |-> (pal_addr[1:0] == 2'b00));

  // R6
  pal_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pal_addr[PAL_W-1:4] == PAL_BASE[PAL_W-1:4]);

endmodule

// File: tb/tb_bg_pixel_shifter.sv
module tb_bg_pixel_shifter;
  localparam int NT = 12;

  logic clk = 0, rst_n = 0, shift_en = 0, reload = 0, bg_en = 1;
  logic [7:0] pat_lo_in = 0, pat_hi_in = 0;
  logic [1:0] attr_in = 0;
  logic [2:0] fine_x = 0;
  logic [1:0] pix_idx;
  logic [13:0] pal_addr;

  int n_chk = 0, n_bad = 0;
  logic [7:0] t_lo [NT];
  logic [7:0] t_hi [NT];
  logic [1:0] t_at [NT];

  bg_pixel_shifter dut (.clk(clk), .rst_n(rst_n), .shift_en(shift_en), .reload(reload),
    .pat_lo_in(pat_lo_in), .pat_hi_in(pat_hi_in), .attr_in(attr_in),
    .fine_x(fine_x), .bg_en(bg_en), .pix_idx(pix_idx), .pal_addr(pal_addr));

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input int tile);
    @(negedge clk);
    shift_en = s;
    reload = (tile >= 0);
    if (tile >= 0) begin
      pat_lo_in = t_lo[tile];
      pat_hi_in = t_hi[tile];
      attr_in = t_at[tile];
    end
    @(posedge clk);
    #1;
  endtask

  // pos: stream position of register bit 0; loaded: number of tiles entered
  task automatic sweep(input string req, input int pos, input int loaded, input logic en);
    for (int f = 0; f < 8; f++) begin
      int q, t, k;
      logic [1:0] ep, ea;
      fine_x = 3'(f);
      bg_en = en;
      #1;
      q = pos + f;
      ep = 0;
      ea = 0;
      if (q >= 0 && q < 8 * loaded) begin
        t = q / 8;
        k = q % 8;
        ep = {t_hi[t][7-k], t_lo[t][7-k]};
        ea = t_at[t];
      end
      if (!en) ep = 0;
      check({req, " pix_idx R5/R9"}, int'(pix_idx), int'(ep));
      check({req, " pal_addr R3/R6"}, int'(pal_addr), int'(14'h3F00 | {ea, ep}));
    end
    bg_en = 1;
  endtask

  initial begin
    int pos, loaded;
    for (int n = 0; n < NT; n++) begin
      t_lo[n] = 8'((n * 53 + 29) & 255);
      t_hi[n] = 8'((n * 101 + 7) & 255);
      t_at[n] = 2'(n % 4);
    end
    t_lo[3] = 8'hFF; t_hi[3] = 8'h00;
    t_lo[4] = 8'h00; t_hi[4] = 8'hFF;
    t_lo[5] = 8'h80; t_hi[5] = 8'h01;

    repeat (3) @(posedge clk);
    #1;
    sweep("R1 reset", -1000, 0, 1'b1);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk);
    #1;
    sweep("R1 after reset", -1000, 0, 1'b1);

    step(1'b0, 0);
    pos = -8;
    loaded = 1;
    sweep("R2 first load", pos, loaded, 1'b1);

    while (pos < 8 * NT + 8) begin
      int nt;
      nt = -1;
      if (pos + 1 >= 0 && (pos + 1) % 8 == 0 && (pos + 1) / 8 + 1 < NT) nt = (pos + 1) / 8 + 1;
      step(1'b1, nt);
      pos++;
      if (nt >= 0) begin
        loaded++;
        sweep("R8 shift+reload", pos, loaded, 1'b1);
      end else if (((pos % 5) + 5) % 5 == 3) begin
        sweep("R7 bg off", pos, loaded, 1'b0);
      end else begin
        sweep("R4 shift", pos, loaded, 1'b1);
      end
      if (((pos % 6) + 6) % 6 == 2) begin
        step(1'b0, -1);
        sweep("R4 hold", pos, loaded, 1'b1);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule